// File: doc/BRIEF.md
# Dynamic On-Die Termination Controller

This block decides, clock by clock, which termination a DDR3-style memory device presents on its data pins. A termination request input is sampled on every rising clock edge together with the decoded write command and a burst-chop flag. The block then drives a two-bit termination code. The code shows either no termination, the nominal value used while the request is held, or a separate write value. The write value replaces the nominal one on the fly for the span of a write burst. Only the registered latencies are modelled. Analog settling windows, resistor values, mode-register decoding and the data path are outside the block.

The latency L that governs every transition is the sum of additive latency and CAS write latency minus two, with a floor of zero. Changes to the request take effect L edges after they are sampled. A write taken while the request is high opens a write window L edges after the command. That window lasts four edges for a burst chop of 4 and six edges for a burst of 8. The block also enforces the rule that the request must stay high for at least four edges. This count starts again at each write command. It raises a one-cycle flag when the request is dropped too early.

Top module: `dyn_term_ctrl`

## Requirements
- R1: A synchronous reset makes the termination code 2'b00 and clears the violation flag on the next edge. It also clears every pending latency event, so requests sampled before the reset never reach the output.
- R2: The termination code is 2'b00 for off, 2'b01 for nominal and 2'b10 for write. The value 2'b11 never appears.
- R3: With no write in progress, a request sampled high at edge n gives the nominal code from edge n+L onward, where L = add_lat + cas_wr_lat - 2.
- R4: With no write in progress, a request sampled low at edge n gives the off code from edge n+L onward.
- R5: A write command sampled at edge m while the request is high gives the write code from edge m+L.
- R6: The write code lasts until edge m+L+4 when wr_bc4 was 1 at the command, or until edge m+L+6 when it was 0. After that the output takes the delayed request state. A following write whose window starts exactly then continues the write code.
- R7: A write command sampled while the request is low has no effect on the output.
- R8: With wrterm_en low, the nominal code is held for the whole write window and 2'b10 never appears.
- R9: With nom_en low, the nominal code never appears. The output is off except during write windows.
- R10: When the request is sampled low at an edge fewer than four edges after it was sampled high, hold_viol is 1 for exactly the cycle that follows that edge. A drop at the fourth edge or later raises no flag.
- R11: A write command sampled with the request high restarts the four-edge hold, so the earliest legal drop is four edges after the command.
- R12: If the delayed request has already gone low while a write window is still open, the write code stays until the window closes and then goes straight to off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| term_req | input | 1 | Termination request sampled each edge |
| wr_cmd | input | 1 | Decoded write command, one cycle per command |
| wr_bc4 | input | 1 | 1: write is a burst chop of 4; 0: burst of 8 |
| add_lat | input | LAT_W | Additive latency in clocks |
| cas_wr_lat | input | LAT_W | CAS write latency in clocks |
| nom_en | input | 1 | Nominal termination enabled |
| wrterm_en | input | 1 | Write termination enabled |
| rtt_code | output | 2 | 00 off, 01 nominal, 10 write |
| hold_viol | output | 1 | One-cycle pulse on an early request drop |

## Verification
A plain request pulse at two latency settings shows that the turn-on and turn-off delays follow the configured sum and are not fixed. Writes of both burst lengths, and back-to-back chopped writes, separate the two return latencies. They also show the seamless join between windows. A long write whose request drops mid-window, repeated with each enable cleared, shows that the later event wins and that each disable acts on its own. A write issued while the request is low, a reset taken in the middle of a pulse, and hold tests with and without a restarting write show that only qualified events enter the pipelines. The hold tests also show that the hold counter restarts on a write.

// File: rtl/dyn_term_ctrl.sv
module dyn_term_ctrl #(
  parameter int LAT_W    = 4,
  parameter int HOLD_CLK = 4,
  parameter int BC4_SPAN = 4,
  parameter int BL8_SPAN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             term_req,
  input  logic             wr_cmd,
  input  logic             wr_bc4,
  input  logic [LAT_W-1:0] add_lat,
  input  logic [LAT_W-1:0] cas_wr_lat,
  input  logic             nom_en,
  input  logic             wrterm_en,
  output logic [1:0]       rtt_code,
  output logic             hold_viol
);
  localparam int MAXL  = 2 * (2**LAT_W - 1);
  localparam int DEPTH = MAXL + BL8_SPAN + 2;
  localparam int CNT_W = $clog2(HOLD_CLK + 1);
  localparam logic [1:0] RTT_OFF = 2'b00;
  localparam logic [1:0] RTT_NOM = 2'b01;
  localparam logic [1:0] RTT_WR  = 2'b10;

  logic [DEPTH-1:0] req_sh, wr_sh, bc_sh;
  logic [CNT_W-1:0] hold_cnt;
  logic [LAT_W:0]   lat_sum, term_lat;
  logic             nom_on, wr_win;

  assign lat_sum  = {1'b0, add_lat} + {1'b0, cas_wr_lat};
  assign term_lat = (lat_sum > (LAT_W+1)'(2)) ? lat_sum - (LAT_W+1)'(2) : '0;

  wire req_rise = term_req & ~req_sh[0];
  wire req_fall = ~term_req & req_sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_sh <= '0;
      wr_sh  <= '0;
      bc_sh  <= '0;
    end else begin
      req_sh <= {req_sh[DEPTH-2:0], term_req};
      wr_sh  <= {wr_sh[DEPTH-2:0], wr_cmd & term_req};
      bc_sh  <= {bc_sh[DEPTH-2:0], wr_bc4};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt  <= '0;
      hold_viol <= 1'b0;
    end else begin
      hold_viol <= req_fall && (hold_cnt != '0);
      if (term_req && (req_rise || wr_cmd))
        hold_cnt <= CNT_W'(HOLD_CLK - 1);
      else if (term_req && hold_cnt != '0)
        hold_cnt <= hold_cnt - CNT_W'(1);
      else if (!term_req)
        hold_cnt <= '0;
    end
  end

  always_comb begin
    nom_on = 1'b0;
    wr_win = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j == int'(term_lat))
        nom_on = req_sh[j];
      if (wr_sh[j] && j >= int'(term_lat) &&
          j < int'(term_lat) + (bc_sh[j] ? BC4_SPAN : BL8_SPAN))
        wr_win = 1'b1;
    end
  end

  assign rtt_code = !(nom_on || wr_win)    ? RTT_OFF :
                    (wr_win && wrterm_en)  ? RTT_WR  :
                    nom_en                 ? RTT_NOM : RTT_OFF;

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rtt_code == RTT_OFF && !hold_viol));
  a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
    rtt_code != 2'b11);
  a_r8_no_wr_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !wrterm_en |-> rtt_code != RTT_WR);
  a_r9_no_nom_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !nom_en |-> rtt_code != RTT_NOM);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    hold_viol |=> !hold_viol);
  a_r10_after_drop: assert property (@(posedge clk) disable iff (rst)
    hold_viol |-> !$past(term_req));
endmodule

// File: tb/test_dyn_term_ctrl.sv
module test_dyn_term_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic term_req = 0, wr_cmd = 0, wr_bc4 = 0, nom_en = 1, wrterm_en = 1;
  logic [3:0] add_lat = 4'd0, cas_wr_lat = 4'd5;
  logic [1:0] rtt_code;
  logic hold_viol;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [1:0] OFF = 2'b00, NOM = 2'b01, WRT = 2'b10;

  always #5 clk = ~clk;

  dyn_term_ctrl i_dyn_term_ctrl (
    .clk(clk), .rst(rst), .term_req(term_req), .wr_cmd(wr_cmd), .wr_bc4(wr_bc4),
    .add_lat(add_lat), .cas_wr_lat(cas_wr_lat), .nom_en(nom_en),
    .wrterm_en(wrterm_en), .rtt_code(rtt_code), .hold_viol(hold_viol));

  task automatic chk(input string req, input int e, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: got %b expected %b", req, e, act, exp);
    end
  endtask

  task automatic cyc(input logic o, input logic w, input logic b);
    @(negedge clk);
    term_req = o; wr_cmd = w; wr_bc4 = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; term_req = 0; wr_cmd = 0; wr_bc4 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R1 code", 0, rtt_code, OFF);
    chk("R1 viol", 0, {1'b0, hold_viol}, 2'b00);
  endtask

  task automatic t_plain_pulse();
    do_reset();
    for (int e = 0; e <= 13; e++) begin
      cyc(e >= 1 && e <= 6, 0, 0);
      chk("R3 R4 pulse", e, rtt_code, (e >= 4 && e <= 9) ? NOM : OFF);
      chk("R10 no flag", e, {1'b0, hold_viol}, 2'b00);
    end
  endtask

  task automatic t_other_latency();
    add_lat = 4'd2; cas_wr_lat = 4'd6;
    do_reset();
    for (int e = 0; e <= 14; e++) begin
      cyc(e >= 1 && e <= 4, 0, 0);
      chk("R3 R4 latency 6", e, rtt_code, (e >= 7 && e <= 10) ? NOM : OFF);
    end
    add_lat = 4'd0; cas_wr_lat = 4'd5;
  endtask

  task automatic t_bc4_write(input logic nom_on);
    nom_en = nom_on;
    do_reset();
    for (int e = 0; e <= 14; e++) begin
      logic [1:0] x;
      cyc(e >= 1 && e <= 7, e == 4, 1);
      x = (e >= 7 && e <= 10) ? WRT : (e >= 4 && e <= 6 && nom_on) ? NOM : OFF;
      chk(nom_on ? "R2 R5 R6 bc4" : "R9 nominal off", e, rtt_code, x);
      chk("R11 legal drop", e, {1'b0, hold_viol}, 2'b00);
    end
    nom_en = 1;
  endtask

  task automatic t_bl8_write();
    do_reset();
    for (int e = 0; e <= 26; e++) begin
      logic [1:0] x;
      cyc(e >= 1 && e <= 20, e == 5, 0);
      x = (e >= 8 && e <= 13) ? WRT : ((e >= 4 && e <= 23) ? NOM : OFF);
      chk("R6 bl8", e, rtt_code, x);
    end
  endtask

  task automatic t_late_drop(input logic wr_on);
    wrterm_en = wr_on;
    do_reset();
    for (int e = 0; e <= 16; e++) begin
      logic [1:0] x;
      cyc(e >= 1 && e <= 8, e == 5, 0);
      if (e >= 8 && e <= 13) x = wr_on ? WRT : NOM;
      else if (e >= 4 && e <= 7) x = NOM;
      else x = OFF;
      chk(wr_on ? "R12 later wins" : "R8 write off", e, rtt_code, x);
      chk("R11 legal drop", e, {1'b0, hold_viol}, 2'b00);
    end
    wrterm_en = 1;
  endtask

  task automatic t_write_req_low();
    do_reset();
    for (int e = 0; e <= 20; e++) begin
      cyc(e >= 6 && e <= 14, e == 3, 0);
      chk("R7 ignored write", e, rtt_code, (e >= 9 && e <= 17) ? NOM : OFF);
    end
  endtask

  task automatic t_back_to_back();
    do_reset();
    for (int e = 0; e <= 35; e++) begin
      logic [1:0] x;
      cyc(e >= 1 && e <= 30, e == 4 || e == 8, 1);
      x = (e >= 7 && e <= 14) ? WRT : ((e >= 4 && e <= 33) ? NOM : OFF);
      chk("R6 seamless", e, rtt_code, x);
    end
  endtask

  task automatic t_hold_rule();
    do_reset();
    for (int e = 0; e <= 26; e++) begin
      cyc((e >= 1 && e <= 3) || (e >= 8 && e <= 12) || (e >= 20 && e <= 23), e == 10, 1);
      chk((e == 13) ? "R11 restart" : "R10 hold", e, {1'b0, hold_viol},
          (e == 4 || e == 13) ? 2'b01 : 2'b00);
    end
  endtask

  task automatic t_reset_midway();
    do_reset();
    cyc(1, 0, 0);
    cyc(1, 0, 0);
    @(negedge clk);
    rst = 1; term_req = 0;
    @(posedge clk);
    #1;
    chk("R1 reset midway", 0, rtt_code, OFF);
    @(negedge clk);
    rst = 0;
    for (int e = 1; e <= 8; e++) begin
      cyc(0, 0, 0);
      chk("R1 pipeline cleared", e, rtt_code, OFF);
    end
  endtask

  initial begin
    t_reset_state();
    t_plain_pulse();
    t_other_latency();
    t_bc4_write(1);
    t_bc4_write(0);
    t_bl8_write();
    t_late_drop(1);
    t_late_drop(0);
    t_write_req_low();
    t_back_to_back();
    t_hold_rule();
    t_reset_midway();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule